// File: doc/BRIEF.md
# One-Hot Sequenced Loop Counter

This block is the circuit that a loop of the form "add one to a small variable, then idle for a fixed number of cycles, forever" turns into. A token held in a one-hot chain of sequencing flops moves from stage to stage. One stage starts the loop. One stage performs the assignment. One or more stages implement the idle delay. The variable sits in a separate register. That register is loaded with its successor only while the assignment stage holds the token.

Every flop clears to zero on reset, so no stage starts out holding the token. A start stage creates the token on the first clock after reset. It does this by detecting that no stage is active. The token then circulates through assignment and delay for as long as reset stays high. Both the variable and the stage vector are outputs, so the loop can be observed cycle by cycle. The variable can be stored in two ways, chosen by a parameter: as a ripple of toggle flops whose toggle enables form a carry chain, or as a plain register loaded from an incrementer.

Top module: `oh_loop_counter`

## Requirements
- R1: While `rst_ni` is low, and at the first clock edge after it rises, `stage_o` and `value_o` are both all zero.
- R2: At the first rising edge after reset is released, the token appears in the start stage (`stage_o` bit 0). The start stage is never active again until the next reset.
- R3: From the first clock edge after reset release onward, exactly one bit of `stage_o` is set in every cycle.
- R4: The assignment stage (`stage_o` bit 1) becomes active in the cycle after the start stage. It also becomes active in the cycle after the last delay stage.
- R5: The delay stages are `stage_o` bits 2 to `DLY_CYC`+1. They receive the token one after another, starting in the cycle after the assignment stage.
- R6: At each clock edge where the assignment stage is active, `value_o` becomes its previous value plus one, modulo 2^`VAL_W`.
- R7: At every other clock edge, `value_o` holds its value.
- R8: Observed from reset, `value_o` reads 0 for two cycles and then climbs by one every `DLY_CYC`+1 cycles. With the default parameters this gives 0,0,1,1,2,2,3,3, after which it wraps back to 0.
- R9: Pulling `rst_ni` low in the middle of a run clears all state. The next release restarts the sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all flops capture on its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| value_o | output | VAL_W | Current value of the loop variable |
| stage_o | output | DLY_CYC+2 | One-hot stage vector: bit 0 start, bit 1 assignment, bits 2 and up delay |

## Verification
Two instances run side by side. The first uses the default 2-bit variable, a single delay stage and toggle-flop storage. It gives the exact 0,0,1,1,2,2,3,3 pattern and wraps after eight cycles of counting. The second uses a 3-bit variable, two delay stages and incrementer storage. It makes the delay chain longer than one stage and exercises the three-bit carry. This shows that each value is held for `DLY_CYC`+1 cycles, and it covers the other storage variant. A reset applied in mid-sequence then shows that both instances restart cleanly.

// File: rtl/oh_loop_pkg.sv
package oh_loop_pkg;
   localparam int unsigned STG_START  = 0;
   localparam int unsigned STG_ASSIGN = 1;
   localparam int unsigned STG_DLY0   = 2;

   function automatic int unsigned stage_total(input int unsigned dly);
      return dly + 2;
   endfunction
endpackage

// File: rtl/oh_token_chain.sv
module oh_token_chain
   import oh_loop_pkg::*;
#(
   parameter int unsigned DLY_CYC = 1,
   localparam int unsigned NSTG   = stage_total(DLY_CYC)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   output logic [NSTG-1:0] stage_q
);
   logic [NSTG-1:0] stage_d;

   // start fires only when no stage holds the token
   assign stage_d[STG_START]  = ~(|stage_q);
   // assignment is entered from start or from the tail of the delay run
   assign stage_d[STG_ASSIGN] = stage_q[STG_START] | stage_q[NSTG-1];

   for (genvar j = 0; j < DLY_CYC; j++) begin : g_dly
      if (j == 0) begin : g_head
         assign stage_d[STG_DLY0] = stage_q[STG_ASSIGN];
      end else begin : g_body
         assign stage_d[STG_DLY0+j] = stage_q[STG_DLY0+j-1];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= stage_d;
   end
endmodule

// File: rtl/oh_var_store.sv
module oh_var_store #(
   parameter int unsigned VAL_W     = 2,
   parameter bit          USE_ADDER = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   output logic [VAL_W-1:0] value_q
);
   if (USE_ADDER) begin : g_adder
      logic [VAL_W-1:0] sum;
      assign sum = value_q + VAL_W'(1);
      always_ff @(posedge clk_i) begin
         if (!rst_ni)     value_q <= '0;
         else if (step_i) value_q <= sum;
      end
   end else begin : g_toggle
      logic [VAL_W:0] carry;
      assign carry[0] = step_i;
      for (genvar i = 0; i < VAL_W; i++) begin : g_bit
         assign carry[i+1] = carry[i] & value_q[i];
         always_ff @(posedge clk_i) begin
            if (!rst_ni)       value_q[i] <= 1'b0;
            else if (carry[i]) value_q[i] <= ~value_q[i];
         end
      end
   end
endmodule

// File: rtl/oh_loop_counter.sv
module oh_loop_counter
   import oh_loop_pkg::*;
#(
   parameter int unsigned VAL_W     = 2,
   parameter int unsigned DLY_CYC   = 1,
   parameter bit          USE_ADDER = 1'b0,
   localparam int unsigned NSTG     = stage_total(DLY_CYC)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [VAL_W-1:0] value_o,
   output logic [NSTG-1:0]  stage_o
);
   if (VAL_W < 1) begin : g_bad_width
      $error("oh_loop_counter: VAL_W must be at least 1");
   end
   if (DLY_CYC < 1) begin : g_bad_delay
      $error("oh_loop_counter: DLY_CYC must be at least 1");
   end

   logic [NSTG-1:0] stage_q;

   oh_token_chain #(.DLY_CYC(DLY_CYC)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stage_q(stage_q)
   );

   oh_var_store #(.VAL_W(VAL_W), .USE_ADDER(USE_ADDER)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (stage_q[STG_ASSIGN]),
      .value_q(value_o)
   );

   assign stage_o = stage_q;
endmodule

// File: rtl/oh_loop_counter_chk.sv
module oh_loop_counter_chk #(
   parameter int unsigned VAL_W   = 2,
   parameter int unsigned DLY_CYC = 1,
   localparam int unsigned NSTG   = DLY_CYC + 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [VAL_W-1:0] value_o,
   input logic [NSTG-1:0]  stage_o
);
   logic seen;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) seen <= 1'b0;
      else         seen <= 1'b1;
   end

   assert_clear_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen |-> (stage_o == '0 && value_o == '0));

   assert_start_to_assign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o[0] |=> (stage_o[1] && !stage_o[0]));

   assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> ($countones(stage_o) == 1));

   assert_loop_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o[NSTG-1] |=> stage_o[1]);

   assert_delay_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o[1] |=> stage_o[2]);

   assert_increment_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o[1] |=> (value_o == VAL_W'($past(value_o) + 1'b1)));

   assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stage_o[1] |=> $stable(value_o));
endmodule

bind oh_loop_counter oh_loop_counter_chk #(.VAL_W(VAL_W), .DLY_CYC(DLY_CYC)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .value_o(value_o),
   .stage_o(stage_o)
);

// File: tb/sim_oh_loop_counter.sv
module sim_oh_loop_counter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   localparam int W0 = 2, D0 = 1;
   localparam int W1 = 3, D1 = 2;

   logic [W0-1:0] val0;
   logic [D0+1:0] stg0;
   logic [W1-1:0] val1;
   logic [D1+1:0] stg1;

   oh_loop_counter u0 (.clk_i(clk), .rst_ni(rst_n), .value_o(val0), .stage_o(stg0));
   oh_loop_counter #(.VAL_W(W1), .DLY_CYC(D1), .USE_ADDER(1'b1)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .value_o(val1), .stage_o(stg1));

   int total = 0;
   int bad = 0;
   int k = 0;
   int cyc = 0;

   always @(posedge clk) begin
      if (!rst_n) k <= 0;
      else        k <= k + 1;
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic int exp_stage(int kk, int dly);
      if (kk == 0) return 0;
      if (kk == 1) return 1;
      return 1 << (1 + ((kk - 2) % (dly + 1)));
   endfunction

   function automatic int exp_val(int kk, int dly, int w);
      if (kk <= 2) return 0;
      return (((kk - 3) / (dly + 1)) + 1) % (1 << w);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
      end
   endtask

   task automatic cmp_all(input string rs, input string rv);
      chk(rs, int'(stg0), exp_stage(k, D0));
      chk(rs, int'(stg1), exp_stage(k, D1));
      chk(rv, int'(val0), exp_val(k, D0, W0));
      chk(rv, int'(val1), exp_val(k, D1, W1));
   endtask

   task automatic t_reset_R1;
      rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R1", int'(stg0) + int'(val0) + int'(stg1) + int'(val1), 0);
      end
   endtask

   task automatic t_start_R2;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", int'(stg0), 1);
      chk("R2", int'(stg1), 1);
      chk("R1", int'(val0) + int'(val1), 0);
      @(negedge clk);
      chk("R4", int'(stg0), 2);
      chk("R4", int'(stg1), 2);
   endtask

   task automatic t_sequence_R5;
      int pv0, pv1, ps0, ps1;
      for (int i = 0; i < 24; i++) begin
         pv0 = int'(val0); pv1 = int'(val1);
         ps0 = int'(stg0); ps1 = int'(stg1);
         @(negedge clk);
         cmp_all("R5", "R6");
         chk("R3", $countones(stg0), 1);
         chk("R3", $countones(stg1), 1);
         chk("R2", int'(stg0[0]) + int'(stg1[0]), 0);
         if (ps0 != 2) chk("R7", int'(val0), pv0);
         if (ps1 != 2) chk("R7", int'(val1), pv1);
      end
   endtask

   task automatic t_wrap_R8;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         cmp_all("R4", "R8");
      end
   endtask

   task automatic t_midreset_R9;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9", int'(stg0) + int'(val0) + int'(stg1) + int'(val1), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         cmp_all("R9", "R9");
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset_R1();
      t_start_R2();
      t_sequence_R5();
      t_wrap_R8();
      t_midreset_R9();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule